// File: doc/BRIEF.md
# Receive frame header validator

This block sits behind a host-side serial link and vets each inbound frame before any payload handling sees it. A 32-bit bus status word arrives first. The block decodes it to learn whether a packet is waiting and how many bytes that packet holds. The frame then streams in one byte per accepted cycle. The block keeps the first 12 bytes as the common frame header. When the frame is addressed to the control channel, it also keeps the 16 bytes that follow as the command header.

For each frame the block reports exactly one verdict: accept, or drop with a reason code. The decoded header fields are shown alongside the verdict. The checks are:
- the 16-bit length must be the bitwise complement of its stored inverse;
- that length must equal the byte count announced by the status word;
- control frames must be long enough to hold the command header.

All multi-byte fields are little-endian. Payload storage and the protocol layers above are left to other logic.

Top module: `rx_frame_checker`

## Requirements
- R1: A status word equal to 0xFFFFFFFF is discarded. The cycle after it, `status_retry` pulses high for one cycle. `pkt_pending` and `pkt_len` keep their values, and no frame is started.
- R2: Any other status word, taken while no frame is in progress, loads `pkt_pending` from bit 8 and `pkt_len` from bits 19:9 in the next cycle. A frame of `pkt_len` bytes is expected only when bit 8 is set.
- R3: A frame shorter than 12 bytes gets result code 1. The result appears in the cycle after its last byte, or in the cycle after the status word when the length is zero.
- R4: Bytes 0-1 hold the length field and bytes 2-3 hold the inverse field. If the length is not the bitwise complement of the inverse, the frame gets code 2. This check takes precedence over R5.
- R5: If the length field is not equal to `pkt_len`, the frame gets code 3.
- R6: The channel is bits 3:0 of byte 5, and byte 4 is the sequence number. A frame on a non-zero channel that passes R3-R5 gets code 0 with `ctl_valid` low. Any verdict decided from the common header is reported in the cycle after byte 11.
- R7: A channel-0 frame that passes R3-R5 but is shorter than 28 bytes gets code 4. The result appears in the cycle after its last byte.
- R8: A channel-0 frame of at least 28 bytes gets code 0 with `ctl_valid` high, in the cycle after byte 27. The command header fields are taken from these bytes:
  - command: bytes 12-15
  - out-length: bytes 16-17
  - in-length: bytes 18-19
  - flags: bytes 20-21
  - id: bytes 22-23
  - status: bytes 24-27
- R9: Each frame produces exactly one `result_valid` pulse. The following bytes have no effect on any result: bytes after the verdict, and bytes offered while no frame is in progress.
- R10: After reset, `pkt_pending`, `pkt_len`, `result_valid` and `status_retry` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_valid | input | 1 | Status word present |
| status_word | input | 32 | Bus status word |
| byte_valid | input | 1 | Frame byte present |
| byte_data | input | 8 | Frame byte |
| status_retry | output | 1 | All-ones status discarded; read it again |
| pkt_pending | output | 1 | Decoded packet-pending flag |
| pkt_len | output | 11 | Decoded packet length in bytes |
| result_valid | output | 1 | One-cycle verdict strobe |
| result_code | output | 3 | 0 ok, 1 short, 2 complement mismatch, 3 length mismatch, 4 short control frame |
| hdr_len | output | 16 | Length field |
| hdr_len_inv | output | 16 | Inverse length field |
| hdr_seq | output | 8 | Sequence byte |
| hdr_channel | output | 4 | Channel number |
| ctl_valid | output | 1 | Command header fields valid |
| ctl_cmd | output | 32 | Command |
| ctl_out_len | output | 16 | Out-length |
| ctl_in_len | output | 16 | In-length |
| ctl_flags | output | 16 | Flags |
| ctl_id | output | 16 | Id |
| ctl_status | output | 32 | Command status |

## Verification
The assertions assume that a status word is only offered while no frame is in progress. They also assume that, once a pending packet is announced, exactly `pkt_len` bytes follow before the next status word. The bench respects both assumptions:
- it sends status words only between frames;
- it drives exactly the announced number of bytes for every frame.

Within those bytes it inserts idle gaps, and it offers stray bytes only while the block is idle. The assertions that relate the accepted fields to the status length therefore never see a frame that was cut short or overrun.

// File: rtl/rx_frame_checker.sv
module rx_frame_checker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        status_valid,
  input  logic [31:0] status_word,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic        status_retry,
  output logic        pkt_pending,
  output logic [10:0] pkt_len,
  output logic        result_valid,
  output logic [2:0]  result_code,
  output logic [15:0] hdr_len,
  output logic [15:0] hdr_len_inv,
  output logic [7:0]  hdr_seq,
  output logic [3:0]  hdr_channel,
  output logic        ctl_valid,
  output logic [31:0] ctl_cmd,
  output logic [15:0] ctl_out_len,
  output logic [15:0] ctl_in_len,
  output logic [15:0] ctl_flags,
  output logic [15:0] ctl_id,
  output logic [31:0] ctl_status
);
  localparam int HDR_BYTES = 12;
  localparam int CTL_BYTES = 16;
  localparam int ALL_BYTES = HDR_BYTES + CTL_BYTES;

  localparam logic [2:0] C_OK    = 3'd0;
  localparam logic [2:0] C_SHORT = 3'd1;
  localparam logic [2:0] C_INV   = 3'd2;
  localparam logic [2:0] C_LEN   = 3'd3;
  localparam logic [2:0] C_CTL   = 3'd4;

  logic                   busy, done;
  logic [10:0]            idx;
  logic [8*HDR_BYTES-1:0] hdr_q;
  logic [8*CTL_BYTES-1:0] ctl_q;
  logic [10:0]            coff;
  logic                   last, emit;
  logic [2:0]             code, common_code;
  logic                   status_ones;

  assign status_ones = (status_word == 32'hFFFF_FFFF);
  assign coff        = idx - 11'(HDR_BYTES);
  assign last        = (idx == pkt_len - 11'd1);

  assign hdr_len     = hdr_q[15:0];
  assign hdr_len_inv = hdr_q[31:16];
  assign hdr_seq     = hdr_q[39:32];
  assign hdr_channel = hdr_q[43:40];
  assign ctl_cmd     = ctl_q[31:0];
  assign ctl_out_len = ctl_q[47:32];
  assign ctl_in_len  = ctl_q[63:48];
  assign ctl_flags   = ctl_q[79:64];
  assign ctl_id      = ctl_q[95:80];
  assign ctl_status  = ctl_q[127:96];

  assign common_code = (hdr_len != ~hdr_len_inv)      ? C_INV :
                       (hdr_len != {5'd0, pkt_len})   ? C_LEN : C_OK;

  always_comb begin
    emit = 1'b0;
    code = C_OK;
    if (busy && byte_valid && !done) begin
      if (pkt_len < 11'(HDR_BYTES)) begin
        emit = last;
        code = C_SHORT;
      end else if (idx == 11'(HDR_BYTES - 1)) begin
        if (common_code != C_OK) begin
          emit = 1'b1;
          code = common_code;
        end else if (hdr_channel != 4'd0) begin
          emit = 1'b1;
        end else if (pkt_len < 11'(ALL_BYTES)) begin
          emit = last;
          code = C_CTL;
        end
      end else if (idx == 11'(ALL_BYTES - 1)) begin
        emit = 1'b1;
      end else if (idx > 11'(HDR_BYTES - 1) && last) begin
        emit = 1'b1;
        code = C_CTL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      done         <= 1'b0;
      idx          <= '0;
      hdr_q        <= '0;
      ctl_q        <= '0;
      status_retry <= 1'b0;
      pkt_pending  <= 1'b0;
      pkt_len      <= '0;
      result_valid <= 1'b0;
      result_code  <= C_OK;
      ctl_valid    <= 1'b0;
    end else begin
      status_retry <= 1'b0;
      result_valid <= 1'b0;
      if (status_valid && !busy) begin
        if (status_ones) begin
          status_retry <= 1'b1;
        end else begin
          pkt_pending <= status_word[8];
          pkt_len     <= status_word[19:9];
          if (status_word[8]) begin
            if (status_word[19:9] == 11'd0) begin
              result_valid <= 1'b1;
              result_code  <= C_SHORT;
              ctl_valid    <= 1'b0;
            end else begin
              busy <= 1'b1;
              done <= 1'b0;
              idx  <= '0;
            end
          end
        end
      end
      if (busy && byte_valid) begin
        if (idx < 11'(HDR_BYTES))
          hdr_q[{idx[3:0], 3'b000} +: 8] <= byte_data;
        else if (idx < 11'(ALL_BYTES))
          ctl_q[{coff[3:0], 3'b000} +: 8] <= byte_data;
        idx <= idx + 11'd1;
        if (last) busy <= 1'b0;
        if (emit) begin
          result_valid <= 1'b1;
          result_code  <= code;
          ctl_valid    <= (code == C_OK) && (hdr_channel == 4'd0);
          done         <= 1'b1;
        end
      end
    end
  end

  assert_retry_holds_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid && !busy && status_ones |=> status_retry && $stable(pkt_len) && $stable(pkt_pending));

  assert_status_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid && !busy && !status_ones |=> pkt_len == $past(status_word[19:9]));

  assert_ok_has_complement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && result_code == C_OK |-> hdr_len == ~hdr_len_inv);

  assert_ok_len_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && result_code == C_OK |-> hdr_len == {5'd0, pkt_len});

  assert_ctl_only_channel0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && ctl_valid |-> result_code == C_OK && hdr_channel == 4'd0 && pkt_len >= 11'(ALL_BYTES));

  assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> result_code <= C_CTL);
endmodule

// File: tb/rx_frame_checker_bench.sv
module rx_frame_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        status_valid = 1'b0;
  logic [31:0] status_word = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        status_retry, pkt_pending, result_valid, ctl_valid;
  logic [10:0] pkt_len;
  logic [2:0]  result_code;
  logic [15:0] hdr_len, hdr_len_inv, ctl_out_len, ctl_in_len, ctl_flags, ctl_id;
  logic [7:0]  hdr_seq;
  logic [3:0]  hdr_channel;
  logic [31:0] ctl_cmd, ctl_status;

  always #2 clk = ~clk;

  rx_frame_checker u_rx_frame_checker (
    .clk(clk), .rst_n(rst_n), .status_valid(status_valid), .status_word(status_word),
    .byte_valid(byte_valid), .byte_data(byte_data), .status_retry(status_retry),
    .pkt_pending(pkt_pending), .pkt_len(pkt_len), .result_valid(result_valid),
    .result_code(result_code), .hdr_len(hdr_len), .hdr_len_inv(hdr_len_inv),
    .hdr_seq(hdr_seq), .hdr_channel(hdr_channel), .ctl_valid(ctl_valid),
    .ctl_cmd(ctl_cmd), .ctl_out_len(ctl_out_len), .ctl_in_len(ctl_in_len),
    .ctl_flags(ctl_flags), .ctl_id(ctl_id), .ctl_status(ctl_status));

  typedef struct packed {
    logic [31:0] trig;
    logic [2:0]  code;
    logic [3:0]  chan;
    logic        ctlv;
    logic [31:0] cmd;
    logic [15:0] id;
    logic [15:0] outl;
  } exp_t;

  localparam logic [15:0] IN_LEN_C = 16'h0011;
  localparam logic [15:0] FLAGS_C  = 16'h2002;
  localparam logic [31:0] STAT_C   = 32'h0BAD_F00D;

  exp_t       q[$];
  int         checks = 0;
  int         errors = 0;
  int         acc = 0;
  logic [7:0] fb [0:63];

  always @(posedge clk) if (byte_valid) acc <= acc + 1;

  task automatic ck(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      if (q.size() == 0) begin
        ck(1'b0, "R9 unexpected result", 64'(result_code), 64'hF);
      end else begin
        exp_t e;
        e = q.pop_front();
        ck(result_code == e.code, "R3-R7 result code", 64'(result_code), 64'(e.code));
        ck(acc == int'(e.trig), "R6 result timing", 64'(acc), 64'(e.trig));
        ck(ctl_valid == e.ctlv, "R8 ctl_valid", 64'(ctl_valid), 64'(e.ctlv));
        if (e.code == 3'd0)
          ck(hdr_channel == e.chan, "R6 channel", 64'(hdr_channel), 64'(e.chan));
        if (e.ctlv) begin
          ck(ctl_cmd == e.cmd, "R8 command", 64'(ctl_cmd), 64'(e.cmd));
          ck(ctl_id == e.id, "R8 id", 64'(ctl_id), 64'(e.id));
          ck(ctl_out_len == e.outl, "R8 out-length", 64'(ctl_out_len), 64'(e.outl));
          ck(ctl_in_len == IN_LEN_C && ctl_flags == FLAGS_C, "R8 in-length/flags",
             {32'(ctl_in_len), 32'(ctl_flags)}, {32'(IN_LEN_C), 32'(FLAGS_C)});
          ck(ctl_status == STAT_C, "R8 status", 64'(ctl_status), 64'(STAT_C));
        end
      end
    end
  end

  task automatic send_status(input logic [31:0] w);
    @(negedge clk);
    status_valid = 1'b1;
    status_word  = w;
    @(negedge clk);
    status_valid = 1'b0;
  endtask

  task automatic run_frame(input int len, input logic [15:0] lenf, input logic [15:0] invf,
                           input logic [7:0] chf, input logic [31:0] cmd,
                           input logic [15:0] id, input logic [15:0] outl);
    exp_t e;
    int   t;
    for (int i = 0; i < 64; i++) fb[i] = 8'(i * 7 + 3);
    {fb[1], fb[0]} = lenf;
    {fb[3], fb[2]} = invf;
    fb[4] = 8'(len + 8'h40);
    fb[5] = chf;
    {fb[15], fb[14], fb[13], fb[12]} = cmd;
    {fb[17], fb[16]} = outl;
    {fb[19], fb[18]} = IN_LEN_C;
    {fb[21], fb[20]} = FLAGS_C;
    {fb[23], fb[22]} = id;
    {fb[27], fb[26], fb[25], fb[24]} = STAT_C;
    e = '0;
    e.chan = chf[3:0];
    e.cmd = cmd; e.id = id; e.outl = outl;
    if (len < 12)                         begin e.code = 3'd1; t = len; end
    else if (lenf != ~invf)               begin e.code = 3'd2; t = 12;  end
    else if (lenf != 16'(len))            begin e.code = 3'd3; t = 12;  end
    else if (chf[3:0] != 4'd0)            begin e.code = 3'd0; t = 12;  end
    else if (len < 28)                    begin e.code = 3'd4; t = len; end
    else                                  begin e.code = 3'd0; t = 28; e.ctlv = 1'b1; end
    e.trig = 32'(acc + t);
    q.push_back(e);
    send_status({12'h5A0, 11'(len), 1'b1, 8'h3C});
    ck(pkt_pending == 1'b1 && pkt_len == 11'(len), "R2 status decode",
       64'(pkt_len), 64'(len));
    for (int i = 0; i < len; i++) begin
      if (i % 5 == 3) begin
        byte_valid = 1'b0;
        @(negedge clk);
      end
      byte_valid = 1'b1;
      byte_data  = fb[i];
      @(negedge clk);
    end
    byte_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    ck(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    ck(!pkt_pending && pkt_len == 11'd0 && !result_valid && !status_retry, "R10 reset state",
       {pkt_pending, 52'd0, pkt_len}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    send_status({12'h000, 11'd37, 1'b0, 8'h00});
    ck(!pkt_pending && pkt_len == 11'd37, "R2 no-packet decode", {pkt_pending, 52'd0, pkt_len}, 64'd37);
    send_status(32'hFFFF_FFFF);
    ck(status_retry == 1'b1, "R1 retry pulse", 64'(status_retry), 64'd1);
    ck(!pkt_pending && pkt_len == 11'd37, "R1 status kept", {pkt_pending, 52'd0, pkt_len}, 64'd37);
    @(negedge clk);
    ck(status_retry == 1'b0, "R1 retry one cycle", 64'(status_retry), 64'd0);

    for (int i = 0; i < 3; i++) begin
      byte_valid = 1'b1;
      byte_data  = 8'hEE;
      @(negedge clk);
    end
    byte_valid = 1'b0;
    repeat (2) @(negedge clk);

    run_frame(20, 16'd20, ~16'd20, 8'h03, 32'h0, 16'h0, 16'h0);
    run_frame(40, 16'd40, ~16'd40, 8'hF0, 32'h1234_5678, 16'h00AB, 16'h0010);
    run_frame(8,  16'd8,  ~16'd8,  8'h00, 32'h0, 16'h0, 16'h0);
    run_frame(0,  16'd0,  16'hFFFF, 8'h00, 32'h0, 16'h0, 16'h0);
    run_frame(20, 16'd20, 16'h1234, 8'h03, 32'h0, 16'h0, 16'h0);
    run_frame(20, 16'd24, ~16'd24, 8'h03, 32'h0, 16'h0, 16'h0);
    run_frame(20, 16'd24, 16'h0000, 8'h03, 32'h0, 16'h0, 16'h0);
    run_frame(20, 16'd20, ~16'd20, 8'h00, 32'h0, 16'h0, 16'h0);
    run_frame(28, 16'd28, ~16'd28, 8'h00, 32'hDEAD_0007, 16'h0102, 16'h0200);
    run_frame(14, 16'd14, ~16'd14, 8'hA5, 32'h0, 16'h0, 16'h0);
    run_frame(12, 16'd12, ~16'd12, 8'h0C, 32'h0, 16'h0, 16'h0);
    run_frame(12, 16'd12, ~16'd12, 8'h70, 32'h0, 16'h0, 16'h0);
    run_frame(11, 16'd11, ~16'd11, 8'h03, 32'h0, 16'h0, 16'h0);

    repeat (10) @(negedge clk);
    ck(q.size() == 0, "R9 every frame reported once", 64'(q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule